// File: doc/BRIEF.md
# Fixed-Point Audio DSP Execution Unit

This block is the arithmetic stage of a small audio signal processor. Each issued instruction brings a 4-bit opcode and three signed 32-bit operands, A, X and Y. One cycle later the block returns a 32-bit result together with a condition-code word. The operations are multiply-accumulate in fractional (Q31) and integer form, each with a saturating or wrapping variant and with an optional negated product. The block also does a three-way add, a masked XOR, signed compare-and-select, and linear interpolation. It keeps a private accumulator. One opcode feeds that accumulator with a fractional product while passing A straight through.

Operand fetch and register-file write-back are handled by the surrounding pipeline. The three opcodes reserved for log conversion, exp conversion and conditional skipping are not executed here. They return A unchanged and raise an unsupported indication for that one result.

Top module: `dsp_exec_unit`

## Requirements
- R1: Opcodes 0x0 and 0x1 return A + ((X·Y) >>> 31) and A + ((−(X·Y)) >>> 31) respectively. The sum is clamped to 0x7FFFFFFF / 0x80000000 when it leaves the signed 32-bit range.
- R2: Opcodes 0x2 and 0x3 compute the same two sums as R1 but keep only the low 32 bits (wraparound).
- R3: Opcode 0x4 returns A + X·Y (full integer product) with saturation. Opcode 0x5 takes bits 30:0 of that sum and sign-extends bit 30 into bit 31.
- R4: Opcode 0x6 returns A + X + Y with saturation.
- R5: Opcode 0x7 returns A. At the same clock edge it adds the low 32 bits of (X·Y) >>> 31 into the accumulator, wrapping, and the new value is visible on the accumulator output one cycle after issue. No other opcode changes the accumulator.
- R6: Opcode 0x8 returns (A & X) ^ Y.
- R7: Comparisons are signed. Opcode 0x9 returns X if A ≥ Y, else ~X. Opcode 0xA returns X if A ≥ Y, else Y. Opcode 0xB returns X if A < Y, else Y.
- R8: Opcode 0xE returns A + ((X·(Y − A)) >>> 31) with saturation. Y − A is formed without overflow.
- R9: Opcodes 0xC, 0xD and 0xF return A, assert the unsupported output for that result only, and leave the accumulator unchanged.
- R10: The condition-code word has the following bits. All other bits are zero.
  - Bit 0: result bit 31 differs from result bit 30.
  - Bit 1: A < Y, signed.
  - Bit 2: result bit 31.
  - Bit 3: result is zero.
  - Bit 4: the result was clamped.
  - Bit 8: result is non-zero.
- R11: An operation issued with the valid strobe appears on the result, flags and output-valid one cycle later. Output-valid and unsupported are low in any cycle after which no operation was issued. In such cycles the result and flags hold their last values.
- R12: A synchronous reset clears the result, flags, output-valid, unsupported and the accumulator to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe for one operation |
| opcode | input | 4 | Operation select |
| op_a | input | 32 | Operand A (signed) |
| op_x | input | 32 | Operand X (signed) |
| op_y | input | 32 | Operand Y (signed) |
| out_valid | output | 1 | Result of an issued operation is present |
| result | output | 32 | Registered result R |
| cc_word | output | 32 | Registered condition-code word |
| unsupported | output | 1 | The presented result came from a non-executed opcode |
| acc_value | output | 32 | Current accumulator contents |

## Verification
The bench instantiates the block at its default 32-bit data width. At that width, operands at the extremes of the full signed range are reachable: the most-negative-times-most-negative product, clamping in both directions, the 31-bit wrap boundary, and interpolation across the full Y − A span. Directed vectors cover these corners, equal-operand compare boundaries and accumulator chains. A long stream of random opcodes and operands with idle gaps and a mid-run reset follows, and the behavioural model is checked against the block on every clock.

// File: rtl/dsp_exec_pkg.sv
package dsp_exec_pkg;

  typedef enum logic [3:0] {
    OP_FMAC_SAT   = 4'h0,
    OP_FMSC_SAT   = 4'h1,
    OP_FMAC_WRAP  = 4'h2,
    OP_FMSC_WRAP  = 4'h3,
    OP_IMAC_SAT   = 4'h4,
    OP_IMAC_WRAP  = 4'h5,
    OP_ADD3_SAT   = 4'h6,
    OP_ACC_MOVE   = 4'h7,
    OP_MASK_XOR   = 4'h8,
    OP_SEL_INV    = 4'h9,
    OP_PICK_GE    = 4'hA,
    OP_PICK_LT    = 4'hB,
    OP_RSV_LOG    = 4'hC,
    OP_RSV_EXP    = 4'hD,
    OP_INTERP     = 4'hE,
    OP_RSV_SKIP   = 4'hF
  } dsp_op_e;

  // condition-code bit positions (decoded by the sequencer)
  localparam int CC_NORM    = 0;
  localparam int CC_BORROW  = 1;
  localparam int CC_MINUS   = 2;
  localparam int CC_ZERO    = 3;
  localparam int CC_SAT     = 4;
  localparam int CC_NONZERO = 8;
  localparam int CC_MIN_W   = CC_NONZERO + 1;

endpackage

// File: rtl/dsp_exec_alu.sv
module dsp_exec_alu
  import dsp_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  dsp_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  input  logic [W-1:0]   acc,
  output logic [W-1:0]   res,
  output logic           sat,
  output logic           borrow,
  output logic           unsup,
  output logic           acc_load,
  output logic [W-1:0]   acc_next
);

  localparam int WP = 2 * W + 2;
  localparam int FR = W - 1;

  typedef logic signed [WP-1:0] wide_t;

  localparam wide_t SMAX = wide_t'({1'b0, {(W-1){1'b1}}});
  localparam wide_t SMIN = ~SMAX;

  function automatic wide_t widen(input logic [W-1:0] v);
    return {{(WP-W){v[W-1]}}, v};
  endfunction

  // returns {clamped, value}
  function automatic logic [W:0] clamp(input wide_t v);
    if (v > SMAX)      return {1'b1, SMAX[W-1:0]};
    else if (v < SMIN) return {1'b1, SMIN[W-1:0]};
    else               return {1'b0, v[W-1:0]};
  endfunction

  function automatic logic [W-1:0] wrap_short(input wide_t v);
    return {v[W-2], v[W-2:0]};
  endfunction

  wide_t ae, xe, ye;
  wide_t p_xy, f_pos, f_neg, s_fpos, s_fneg, s_int, s_add3;
  wide_t diff, p_ip, f_ip, s_ip;
  logic [W:0] c_fpos, c_fneg, c_int, c_add3, c_ip;
  logic a_ge_y;

  always_comb begin
    ae     = widen(a);
    xe     = widen(x);
    ye     = widen(y);
    p_xy   = xe * ye;
    f_pos  = p_xy >>> FR;
    f_neg  = (-p_xy) >>> FR;
    s_fpos = ae + f_pos;
    s_fneg = ae + f_neg;
    s_int  = ae + p_xy;
    s_add3 = ae + xe + ye;
    diff   = ye - ae;
    p_ip   = xe * diff;
    f_ip   = p_ip >>> FR;
    s_ip   = ae + f_ip;
    c_fpos = clamp(s_fpos);
    c_fneg = clamp(s_fneg);
    c_int  = clamp(s_int);
    c_add3 = clamp(s_add3);
    c_ip   = clamp(s_ip);
    a_ge_y = $signed(a) >= $signed(y);
  end

  assign borrow   = ~a_ge_y;
  assign acc_load = (op == OP_ACC_MOVE);
  assign acc_next = acc + f_pos[W-1:0];

  always_comb begin
    res   = a;
    sat   = 1'b0;
    unsup = 1'b0;
    unique case (op)
      OP_FMAC_SAT:  {sat, res} = c_fpos;
      OP_FMSC_SAT:  {sat, res} = c_fneg;
      OP_FMAC_WRAP: res = s_fpos[W-1:0];
      OP_FMSC_WRAP: res = s_fneg[W-1:0];
      OP_IMAC_SAT:  {sat, res} = c_int;
      OP_IMAC_WRAP: res = wrap_short(s_int);
      OP_ADD3_SAT:  {sat, res} = c_add3;
      OP_ACC_MOVE:  res = a;
      OP_MASK_XOR:  res = (a & x) ^ y;
      OP_SEL_INV:   res = a_ge_y ? x : ~x;
      OP_PICK_GE:   res = a_ge_y ? x : y;
      OP_PICK_LT:   res = a_ge_y ? y : x;
      OP_INTERP:    {sat, res} = c_ip;
      default: begin
        res   = a;
        unsup = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/dsp_exec_ccgen.sv
module dsp_exec_ccgen
  import dsp_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] res,
  input  logic         sat,
  input  logic         borrow,
  output logic [W-1:0] cc
);

  localparam bit W_OK = (W >= CC_MIN_W);

  generate
    if (!W_OK) begin : g_bad_width
      initial $error("dsp_exec_ccgen: width too small for condition word");
    end
  endgenerate

  logic is_zero;
  assign is_zero = (res == '0);

  always_comb begin
    cc              = '0;
    cc[CC_NORM]     = res[W-1] ^ res[W-2];
    cc[CC_BORROW]   = borrow;
    cc[CC_MINUS]    = res[W-1];
    cc[CC_ZERO]     = is_zero;
    cc[CC_SAT]      = sat;
    cc[CC_NONZERO]  = ~is_zero;
  end

endmodule

// File: rtl/dsp_exec_acc.sv
module dsp_exec_acc #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] next,
  output logic [W-1:0] acc
);

  always_ff @(posedge clk) begin
    if (rst)       acc <= '0;
    else if (load) acc <= next;
  end

endmodule

// File: rtl/dsp_exec_unit.sv
module dsp_exec_unit
  import dsp_exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [3:0]   opcode,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_x,
  input  logic [W-1:0] op_y,
  output logic         out_valid,
  output logic [W-1:0] result,
  output logic [W-1:0] cc_word,
  output logic         unsupported,
  output logic [W-1:0] acc_value
);

  localparam logic [W-1:0] POS_LIM = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_LIM = {1'b1, {(W-1){1'b0}}};

  dsp_op_e      op;
  logic [W-1:0] alu_res, alu_acc_next, cc_next;
  logic         alu_sat, alu_borrow, alu_unsup, alu_acc_load;
  logic         acc_we;

  assign op     = dsp_op_e'(opcode);
  assign acc_we = in_valid & alu_acc_load;

  dsp_exec_alu #(.W(W)) i_alu (
    .op       (op),
    .a        (op_a),
    .x        (op_x),
    .y        (op_y),
    .acc      (acc_value),
    .res      (alu_res),
    .sat      (alu_sat),
    .borrow   (alu_borrow),
    .unsup    (alu_unsup),
    .acc_load (alu_acc_load),
    .acc_next (alu_acc_next)
  );

  dsp_exec_ccgen #(.W(W)) i_ccgen (
    .res    (alu_res),
    .sat    (alu_sat),
    .borrow (alu_borrow),
    .cc     (cc_next)
  );

  dsp_exec_acc #(.W(W)) i_acc (
    .clk  (clk),
    .rst  (rst),
    .load (acc_we),
    .next (alu_acc_next),
    .acc  (acc_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      unsupported <= 1'b0;
      result      <= '0;
      cc_word     <= '0;
    end else begin
      out_valid   <= in_valid;
      unsupported <= in_valid & alu_unsup;
      if (in_valid) begin
        result  <= alu_res;
        cc_word <= cc_next;
      end
    end
  end

  AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);  // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid && !unsupported && $stable(result) && $stable(cc_word));  // R11
  AST_ACC_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && opcode == OP_ACC_MOVE) |=> $stable(acc_value));  // R5
  AST_RSV_PASS: assert property (@(posedge clk) disable iff (rst)
    in_valid && (opcode == OP_RSV_LOG || opcode == OP_RSV_EXP || opcode == OP_RSV_SKIP)
    |=> unsupported && result == $past(op_a));  // R9
  AST_PICK_SOURCE: assert property (@(posedge clk) disable iff (rst)
    in_valid && (opcode == OP_PICK_GE || opcode == OP_PICK_LT)
    |=> result == $past(op_x) || result == $past(op_y));  // R7
  AST_CLAMP_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid && cc_word[CC_SAT] |-> result == POS_LIM || result == NEG_LIM);  // R1
  AST_ZERO_EXCL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cc_word[CC_ZERO] != cc_word[CC_NONZERO]);  // R10
  AST_MASK_XOR: assert property (@(posedge clk) disable iff (rst)
    in_valid && opcode == OP_MASK_XOR |=> result == (($past(op_a) & $past(op_x)) ^ $past(op_y)));  // R6
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> !out_valid && !unsupported && acc_value == '0 && result == '0);  // R12

endmodule

// File: tb/test_dsp_exec_unit.sv
module test_dsp_exec_unit;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [3:0]  opcode;
  logic [31:0] op_a, op_x, op_y;
  logic        out_valid, unsupported;
  logic [31:0] result, cc_word, acc_value;

  always #2 clk = ~clk;  // 250 MHz

  dsp_exec_unit #(.W(32)) i_dsp_exec_unit (
    .clk, .rst, .in_valid, .opcode, .op_a, .op_x, .op_y,
    .out_valid, .result, .cc_word, .unsupported, .acc_value
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // reference state
  bit          m_valid, m_unsup, m_rst;
  logic [31:0] m_res, m_cc, m_acc;
  int          m_op;

  function automatic string tag_of(int op);
    case (op)
      0, 1:      return "R1";
      2, 3:      return "R2";
      4, 5:      return "R3";
      6:         return "R4";
      7:         return "R5";
      8:         return "R6";
      9, 10, 11: return "R7";
      14:        return "R8";
      default:   return "R9";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic void clamp32(input logic signed [127:0] v,
                                  output logic [31:0] r, output bit s);
    s = 1'b1;
    if (v > 128'sd2147483647)       r = 32'h7fffffff;
    else if (v < -128'sd2147483648) r = 32'h80000000;
    else begin r = v[31:0]; s = 1'b0; end
  endfunction

  task automatic model(bit r_i, bit v, int op, logic [31:0] a, logic [31:0] x, logic [31:0] y);
    logic signed [127:0] bA, bX, bY, t;
    logic [31:0] r;
    bit s, un;
    m_rst = r_i;
    if (r_i) begin
      m_valid = 0; m_unsup = 0; m_res = 0; m_cc = 0; m_acc = 0; m_op = 0;
      return;
    end
    if (!v) begin m_valid = 0; m_unsup = 0; return; end
    bA = $signed(a); bX = $signed(x); bY = $signed(y);
    s = 0; un = 0; r = a;
    case (op)
      0: clamp32(bA + ((bX * bY) >>> 31), r, s);
      1: clamp32(bA + ((-(bX * bY)) >>> 31), r, s);
      2: begin t = bA + ((bX * bY) >>> 31); r = t[31:0]; end
      3: begin t = bA + ((-(bX * bY)) >>> 31); r = t[31:0]; end
      4: clamp32(bA + bX * bY, r, s);
      5: begin t = bA + bX * bY; r = {t[30], t[30:0]}; end
      6: clamp32(bA + bX + bY, r, s);
      7: begin r = a; t = (bX * bY) >>> 31; m_acc = m_acc + t[31:0]; end
      8: r = (a & x) ^ y;
      9: r = ($signed(a) >= $signed(y)) ? x : ~x;
      10: r = ($signed(a) >= $signed(y)) ? x : y;
      11: r = ($signed(a) < $signed(y)) ? x : y;
      14: clamp32(bA + ((bX * (bY - bA)) >>> 31), r, s);
      default: begin r = a; un = 1; end
    endcase
    m_valid = 1; m_unsup = un; m_res = r; m_op = op;
    m_cc = 0;
    m_cc[0] = r[31] ^ r[30];
    m_cc[1] = $signed(a) < $signed(y);
    m_cc[2] = r[31];
    m_cc[3] = (r == 0);
    m_cc[4] = s;
    m_cc[8] = (r != 0);
  endtask

  task automatic compare_all();
    string rq;
    rq = m_rst ? "R12" : tag_of(m_op);
    chk(m_rst ? "R12" : "R11", "out_valid", {31'd0, out_valid}, {31'd0, m_valid});
    chk(rq, "result", result, m_res);
    chk(m_rst ? "R12" : "R10", "cc_word", cc_word, m_cc);
    chk(m_rst ? "R12" : "R9", "unsupported", {31'd0, unsupported}, {31'd0, m_unsup});
    chk(m_rst ? "R12" : "R5", "acc_value", acc_value, m_acc);
  endtask

  task automatic step(bit r_i, bit v, int op, logic [31:0] a, logic [31:0] x, logic [31:0] y);
    @(negedge clk);
    compare_all();
    rst = r_i; in_valid = v; opcode = op[3:0]; op_a = a; op_x = x; op_y = y;
    model(r_i, v, op, a, x, y);
  endtask

  task automatic issue(int op, logic [31:0] a, logic [31:0] x, logic [31:0] y);
    step(0, 1, op, a, x, y);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 32'hdeadbeef, 32'h1234, 32'h5678);
  endtask

  initial begin
    rst = 1; in_valid = 0; opcode = 0; op_a = 0; op_x = 0; op_y = 0;
    m_valid = 0; m_unsup = 0; m_res = 0; m_cc = 0; m_acc = 0; m_op = 0; m_rst = 1;
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 0);   // R12 reset state
    // R1 fractional saturating
    issue(0, 32'h10000000, 32'h40000000, 32'h40000000);
    issue(0, 32'h7fffffff, 32'h7fffffff, 32'h7fffffff);
    issue(0, 32'h00000000, 32'h80000000, 32'h80000000);
    issue(1, 32'h00000000, 32'h40000000, 32'h40000000);
    issue(1, 32'h80000000, 32'h40000000, 32'h40000000);
    // R2 wraparound
    issue(2, 32'h7fffffff, 32'h7fffffff, 32'h7fffffff);
    issue(3, 32'h80000000, 32'h40000000, 32'h40000000);
    issue(2, 32'h00000000, 32'h80000000, 32'h80000000);
    // R3 integer MAC
    issue(4, 32'd100, 32'd7, 32'hfffffffd);
    issue(4, 32'h0, 32'h00010000, 32'h00010000);
    issue(5, 32'h0, 32'h00010000, 32'h00010000);
    issue(5, 32'h3fffffff, 32'h1, 32'h1);
    // R4 triple add
    issue(6, 32'd1, 32'd2, 32'd3);
    issue(6, 32'h80000000, 32'h80000000, 32'h0);
    idle(2);
    // R5 accumulator chain
    issue(7, 32'hcafe0001, 32'h40000000, 32'h40000000);
    issue(7, 32'h00000005, 32'h80000000, 32'h80000000);
    issue(7, 32'h00000006, 32'hc0000000, 32'h40000000);
    // R6 mask xor
    issue(8, 32'hf0f0f0f0, 32'hff00ff00, 32'h0f0f0f0f);
    // R7 compares incl. equality and sign
    issue(9, 32'd5, 32'h12345678, 32'd5);
    issue(9, 32'hffffffff, 32'h12345678, 32'd1);
    issue(10, 32'd7, 32'haaaa, 32'd7);
    issue(10, 32'h80000000, 32'haaaa, 32'h7fffffff);
    issue(11, 32'd7, 32'haaaa, 32'd7);
    issue(11, 32'hfffffff0, 32'haaaa, 32'd3);
    // R8 interpolation
    issue(14, 32'h0, 32'h40000000, 32'h7fffffff);
    issue(14, 32'h7fffffff, 32'h80000000, 32'h80000000);
    issue(14, 32'h20000000, 32'h0, 32'h60000000);
    // R9 reserved opcodes
    issue(12, 32'h55aa55aa, 32'h1, 32'h2);
    issue(13, 32'h00000000, 32'h40000000, 32'h40000000);
    issue(15, 32'h80000000, 32'h3, 32'h4);
    idle(3);  // R11 hold while idle
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 4) == 0) idle(1);
      else issue($urandom_range(0, 15), $urandom, $urandom, $urandom);
    end
    step(1, 1, 7, 32'h1, 32'h40000000, 32'h40000000);  // R12 mid-run reset
    step(0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 500; i++)
      issue($urandom_range(0, 15), $urandom, $urandom, $urandom);
    idle(2);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule